// File: doc/BRIEF.md
# Load-to-Store Forwarding and Load-Use Hazard Unit

This block sits beside the memory stage of a five-stage in-order pipeline. It handles one pattern: a load that writes a register, followed at once by a store that writes that same register back to memory. A plain load-use interlock would stall that pair for one cycle. This block lets the pair run back to back. The store is allowed to advance. When the store reaches the memory stage, the loaded value held in the writeback-stage pipeline register is steered into the write-data input of data memory in place of the stale register-file value.

The unit has three parts:
- a forwarding select, which is a single equation over pipeline-register fields;
- a two-way store-data multiplexer in front of data memory;
- a revised load-use stall detector.

The stall detector still holds the program counter and the fetch/decode register, and still injects a bubble, for every load-use case except the exempt store-data match. All pins carry control or field values that are valid each cycle. There is no streaming handshake on any of them, so no back-pressure rule applies. The parameter `STORE_FWD` selects the revised behaviour (1) or the classic interlock with no store forwarding (0).

Top module: `ldst_fwd_unit`

## Requirements
- R1: `fwd_store_sel` is 1 exactly when all of the following hold: `memwb_regwrite`=1, `memwb_memtoreg`=1, `memwb_rd`≠0, `exmem_memwrite`=1 and `exmem_rt`==`memwb_rd` (with `STORE_FWD`=1).
- R2: `mem_write_data` equals `memwb_load_data` when `fwd_store_sel`=1, and equals `exmem_store_data` otherwise.
- R3: Register 0 is never a forwarding source. With `memwb_rd`=0, `fwd_store_sel` stays 0 whatever the other fields are.
- R4: With `idex_memread`=0, `stall` is 0.
- R5: A store in decode (`ifid_memwrite`=1) whose only match with `idex_rt` is on `ifid_rt` does not stall when `STORE_FWD`=1.
- R6: When `idex_memread`=1 and `idex_rt`==`ifid_rs`, `stall` is 1. This holds even when the decode instruction is a store, i.e. when the load writes the store's base register.
- R7: When `stall`=1, the outputs are `pc_write_en`=0, `ifid_write_en`=0 and `idex_bubble`=1. When `stall`=0, the outputs are 1, 1 and 0.
- R8: A non-store in decode (`ifid_memwrite`=0) with `idex_memread`=1 and `idex_rt`==`ifid_rt` stalls.
- R9: With `STORE_FWD`=0, `fwd_store_sel` is always 0 and a load followed by a store of the loaded register stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | AW | Decode-stage first source register (store base) |
| ifid_rt | input | AW | Decode-stage second source register (store data) |
| ifid_memwrite | input | 1 | Decode-stage instruction is a store |
| idex_rt | input | AW | Execute-stage load destination register |
| idex_memread | input | 1 | Execute-stage instruction is a load |
| exmem_rt | input | AW | Memory-stage store data register number |
| exmem_memwrite | input | 1 | Memory-stage instruction is a store |
| exmem_store_data | input | DW | Store data carried in the execute/memory register |
| memwb_rd | input | AW | Writeback-stage destination register |
| memwb_regwrite | input | 1 | Writeback-stage instruction writes a register |
| memwb_memtoreg | input | 1 | Writeback value comes from memory (load) |
| memwb_load_data | input | DW | Loaded value held in the memory/writeback register |
| fwd_store_sel | output | 1 | Store-data mux select: 1 selects the writeback value |
| mem_write_data | output | DW | Write data presented to data memory |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_write_en | output | 1 | Program counter update enable |
| ifid_write_en | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Clear control bits entering the execute stage |

## Verification
The bench builds two instances with the default widths (AW=5, DW=32). The first uses `STORE_FWD`=1. The second uses `STORE_FWD`=0. Comparing them in the same cycle shows that only the exempt store-data match differs between the two: that pair stalls in one variant and passes through in the other. Random register numbers are drawn from a narrow range so that matches, register 0 and base-versus-data collisions occur often.

// File: rtl/ldst_fwd_pkg.sv
package ldst_fwd_pkg;
  typedef enum logic {
    SDATA_PIPE = 1'b0,
    SDATA_WB   = 1'b1
  } sdata_src_e;
endpackage

// File: rtl/ldst_fwd_select.sv
module ldst_fwd_select
  import ldst_fwd_pkg::*;
#(
  parameter int AW        = 5,
  parameter bit STORE_FWD = 1'b1
) (
  input  logic [AW-1:0] exmem_rt,
  input  logic          exmem_memwrite,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_regwrite,
  input  logic          memwb_memtoreg,
  output sdata_src_e    src
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  generate
    if (STORE_FWD) begin : g_fwd
      logic wb_is_load, reg_hit;
      always_comb begin
        wb_is_load = memwb_regwrite && memwb_memtoreg && (memwb_rd != ZERO_REG);
        reg_hit    = exmem_memwrite && (exmem_rt == memwb_rd);
        src        = (wb_is_load && reg_hit) ? SDATA_WB : SDATA_PIPE;
      end
    end else begin : g_nofwd
      assign src = SDATA_PIPE;
    end
  endgenerate

  always_comb begin
    a_r3_no_zero_source: assert (!(src == SDATA_WB && memwb_rd == ZERO_REG))
      else $error("R3: forwarding from register 0");
  end
endmodule

// File: rtl/ldst_store_mux.sv
module ldst_store_mux
  import ldst_fwd_pkg::*;
#(
  parameter int DW = 32
) (
  input  sdata_src_e    src,
  input  logic [DW-1:0] pipe_data,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] wdata
);
  always_comb begin
    unique case (src)
      SDATA_WB:   wdata = wb_data;
      default:    wdata = pipe_data;
    endcase
  end

  always_comb begin
    a_r2_mux_follows_sel: assert ((src == SDATA_WB) ? (wdata == wb_data) : (wdata == pipe_data))
      else $error("R2: store data mux output wrong");
  end
endmodule

// File: rtl/ldst_hazard_detect.sv
module ldst_hazard_detect #(
  parameter int AW        = 5,
  parameter bit STORE_FWD = 1'b1
) (
  input  logic [AW-1:0] ifid_rs,
  input  logic [AW-1:0] ifid_rt,
  input  logic          ifid_memwrite,
  input  logic [AW-1:0] idex_rt,
  input  logic          idex_memread,
  output logic          hazard
);
  logic base_hit, data_hit, data_exempt;

  always_comb begin
    base_hit = (idex_rt == ifid_rs);
    data_hit = (idex_rt == ifid_rt);
  end

  generate
    if (STORE_FWD) begin : g_exempt
      assign data_exempt = ifid_memwrite;
    end else begin : g_classic
      assign data_exempt = 1'b0;
    end
  endgenerate

  always_comb begin
    hazard = idex_memread && (base_hit || (data_hit && !data_exempt));
  end

  always_comb begin
    a_r4_no_load_no_stall: assert (idex_memread || !hazard)
      else $error("R4: stall without a load in execute");
  end
endmodule

// File: rtl/ldst_fwd_unit.sv
module ldst_fwd_unit
  import ldst_fwd_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 32,
  parameter bit STORE_FWD = 1'b1
) (
  input  logic [AW-1:0] ifid_rs,
  input  logic [AW-1:0] ifid_rt,
  input  logic          ifid_memwrite,
  input  logic [AW-1:0] idex_rt,
  input  logic          idex_memread,
  input  logic [AW-1:0] exmem_rt,
  input  logic          exmem_memwrite,
  input  logic [DW-1:0] exmem_store_data,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_regwrite,
  input  logic          memwb_memtoreg,
  input  logic [DW-1:0] memwb_load_data,
  output logic          fwd_store_sel,
  output logic [DW-1:0] mem_write_data,
  output logic          stall,
  output logic          pc_write_en,
  output logic          ifid_write_en,
  output logic          idex_bubble
);
  sdata_src_e src;
  logic       hazard;

  ldst_fwd_select #(.AW(AW), .STORE_FWD(STORE_FWD)) u_sel (
    .exmem_rt       (exmem_rt),
    .exmem_memwrite (exmem_memwrite),
    .memwb_rd       (memwb_rd),
    .memwb_regwrite (memwb_regwrite),
    .memwb_memtoreg (memwb_memtoreg),
    .src            (src)
  );

  ldst_store_mux #(.DW(DW)) u_mux (
    .src       (src),
    .pipe_data (exmem_store_data),
    .wb_data   (memwb_load_data),
    .wdata     (mem_write_data)
  );

  ldst_hazard_detect #(.AW(AW), .STORE_FWD(STORE_FWD)) u_haz (
    .ifid_rs       (ifid_rs),
    .ifid_rt       (ifid_rt),
    .ifid_memwrite (ifid_memwrite),
    .idex_rt       (idex_rt),
    .idex_memread  (idex_memread),
    .hazard        (hazard)
  );

  always_comb begin
    fwd_store_sel = (src == SDATA_WB);
    stall         = hazard;
    pc_write_en   = !hazard;
    ifid_write_en = !hazard;
    idex_bubble   = hazard;
  end

  always_comb begin
    a_r6_base_match_stalls: assert (!(idex_memread && idex_rt == ifid_rs) || stall)
      else $error("R6: base register load-use did not stall");
    a_r8_nonstore_stalls: assert (!(idex_memread && !ifid_memwrite && idex_rt == ifid_rt) || stall)
      else $error("R8: non-store load-use did not stall");
    a_r1_fwd_needs_store_in_mem: assert (!fwd_store_sel || (exmem_memwrite && memwb_memtoreg))
      else $error("R1: forwarding without load/store pair");
    a_r9_classic_no_fwd: assert (STORE_FWD || !fwd_store_sel)
      else $error("R9: forwarding in classic variant");
  end
endmodule

// File: tb/tb_ldst_fwd_unit.sv
module tb_ldst_fwd_unit;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] ifid_rs, ifid_rt, idex_rt, exmem_rt, memwb_rd;
  logic ifid_memwrite, idex_memread, exmem_memwrite, memwb_regwrite, memwb_memtoreg;
  logic [DW-1:0] exmem_store_data, memwb_load_data;

  logic fs1, st1, pc1, iw1, bb1; logic [DW-1:0] wd1;
  logic fs0, st0, pc0, iw0, bb0; logic [DW-1:0] wd0;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  ldst_fwd_unit #(.AW(AW), .DW(DW), .STORE_FWD(1'b1)) dut (
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .ifid_memwrite(ifid_memwrite),
    .idex_rt(idex_rt), .idex_memread(idex_memread),
    .exmem_rt(exmem_rt), .exmem_memwrite(exmem_memwrite), .exmem_store_data(exmem_store_data),
    .memwb_rd(memwb_rd), .memwb_regwrite(memwb_regwrite), .memwb_memtoreg(memwb_memtoreg),
    .memwb_load_data(memwb_load_data),
    .fwd_store_sel(fs1), .mem_write_data(wd1), .stall(st1),
    .pc_write_en(pc1), .ifid_write_en(iw1), .idex_bubble(bb1)
  );

  ldst_fwd_unit #(.AW(AW), .DW(DW), .STORE_FWD(1'b0)) dut_classic (
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .ifid_memwrite(ifid_memwrite),
    .idex_rt(idex_rt), .idex_memread(idex_memread),
    .exmem_rt(exmem_rt), .exmem_memwrite(exmem_memwrite), .exmem_store_data(exmem_store_data),
    .memwb_rd(memwb_rd), .memwb_regwrite(memwb_regwrite), .memwb_memtoreg(memwb_memtoreg),
    .memwb_load_data(memwb_load_data),
    .fwd_store_sel(fs0), .mem_write_data(wd0), .stall(st0),
    .pc_write_en(pc0), .ifid_write_en(iw0), .idex_bubble(bb0)
  );

  task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference derived from the requirements.
  function automatic bit model_fwd(input bit en);
    if (!en) return 1'b0;                           // R9
    if (memwb_rd == 0) return 1'b0;                 // R3
    if (!(memwb_regwrite && memwb_memtoreg)) return 1'b0;
    if (!exmem_memwrite) return 1'b0;
    return int'(exmem_rt) == int'(memwb_rd);        // R1
  endfunction

  function automatic bit model_stall(input bit en);
    int ld, rs, rt;
    ld = idex_rt; rs = ifid_rs; rt = ifid_rt;
    if (!idex_memread) return 1'b0;                 // R4
    if (ld == rs) return 1'b1;                      // R6
    if (ld == rt) return !(en && ifid_memwrite);    // R5, R8
    return 1'b0;
  endfunction

  task automatic compare_all(input string tag);
    bit f1, f0, s1, s0;
    f1 = model_fwd(1'b1); f0 = model_fwd(1'b0);
    s1 = model_stall(1'b1); s0 = model_stall(1'b0);
    check({tag, "/R1"}, "fwd_store_sel", DW'(fs1), DW'(f1));
    check({tag, "/R2"}, "mem_write_data", wd1, f1 ? memwb_load_data : exmem_store_data);
    check({tag, "/R5"}, "stall", DW'(st1), DW'(s1));
    check({tag, "/R7"}, "pc_write_en", DW'(pc1), DW'(!s1));
    check({tag, "/R7"}, "ifid_write_en", DW'(iw1), DW'(!s1));
    check({tag, "/R7"}, "idex_bubble", DW'(bb1), DW'(s1));
    check({tag, "/R9"}, "classic fwd", DW'(fs0), DW'(f0));
    check({tag, "/R9"}, "classic stall", DW'(st0), DW'(s0));
    check({tag, "/R9"}, "classic wdata", wd0, exmem_store_data);
    check({tag, "/R9"}, "classic pc_we", DW'(pc0), DW'(!s0));
    check({tag, "/R9"}, "classic ifid_we", DW'(iw0), DW'(!s0));
    check({tag, "/R9"}, "classic bubble", DW'(bb0), DW'(s0));
  endtask

  task automatic clear_inputs();
    ifid_rs = '0; ifid_rt = '0; ifid_memwrite = 1'b0;
    idex_rt = '0; idex_memread = 1'b0;
    exmem_rt = '0; exmem_memwrite = 1'b0; exmem_store_data = 32'h1111_2222;
    memwb_rd = '0; memwb_regwrite = 1'b0; memwb_memtoreg = 1'b0; memwb_load_data = 32'hAAAA_5555;
  endtask

  // Inputs change just after a rising edge; outputs are sampled at the falling edge.
  task automatic step(input string tag);
    @(negedge clk);
    compare_all(tag);
    @(posedge clk);
    #1;
  endtask

  initial begin
    clear_inputs();
    repeat (2) @(posedge clk);
    #1;
    // Reset state: idle pipeline gives no stall and no forwarding (R4, R7).
    @(negedge clk);
    check("R4", "reset stall", DW'(st1), '0);
    check("R7", "reset pc_we", DW'(pc1), DW'(1));
    check("R1", "reset fwd", DW'(fs1), '0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5: lw r7 in execute, sw r7 in decode, different base -> no stall; classic stalls (R9).
    idex_memread = 1; idex_rt = 7; ifid_memwrite = 1; ifid_rt = 7; ifid_rs = 9;
    @(negedge clk);
    check("R5", "store-data exempt stall", DW'(st1), '0);
    check("R9", "classic store-data stall", DW'(st0), DW'(1));
    compare_all("R5");
    @(posedge clk); #1;

    // R6: load targets the store's base register -> stall in both variants.
    ifid_rs = 7; ifid_rt = 3;
    @(negedge clk);
    check("R6", "base match stall", DW'(st1), DW'(1));
    check("R7", "bubble on stall", DW'(bb1), DW'(1));
    check("R7", "ifid hold on stall", DW'(iw1), '0);
    @(posedge clk); #1;

    // R8: non-store reading loaded reg in rt stalls.
    clear_inputs(); idex_memread = 1; idex_rt = 4; ifid_rt = 4; ifid_rs = 2;
    @(negedge clk);
    check("R8", "non-store rt stall", DW'(st1), DW'(1));
    @(posedge clk); #1;

    // R1/R2: load in writeback, store of same reg in memory stage -> forward.
    clear_inputs(); memwb_regwrite = 1; memwb_memtoreg = 1; memwb_rd = 7;
    exmem_memwrite = 1; exmem_rt = 7; memwb_load_data = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R1", "forward select", DW'(fs1), DW'(1));
    check("R2", "forwarded data", wd1, 32'hDEAD_BEEF);
    check("R9", "classic no forward", DW'(fs0), '0);
    @(posedge clk); #1;

    // R3: destination register 0 never forwards.
    memwb_rd = 0; exmem_rt = 0;
    @(negedge clk);
    check("R3", "zero reg no forward", DW'(fs1), '0);
    check("R2", "pipe data when not forwarding", wd1, exmem_store_data);
    @(posedge clk); #1;

    // R1: ALU result (not a load) in writeback does not forward.
    memwb_rd = 5; exmem_rt = 5; memwb_memtoreg = 0;
    @(negedge clk);
    check("R1", "non-load writeback no forward", DW'(fs1), '0);
    @(posedge clk); #1;

    // Random phase, registers drawn from 0..3 to force collisions.
    for (int i = 0; i < 3000; i++) begin
      ifid_rs = AW'($urandom_range(0, 3)); ifid_rt = AW'($urandom_range(0, 3));
      idex_rt = AW'($urandom_range(0, 3)); exmem_rt = AW'($urandom_range(0, 3));
      memwb_rd = AW'($urandom_range(0, 3));
      ifid_memwrite = 1'($urandom_range(0, 1)); idex_memread = 1'($urandom_range(0, 1));
      exmem_memwrite = 1'($urandom_range(0, 1)); memwb_regwrite = 1'($urandom_range(0, 1));
      memwb_memtoreg = 1'($urandom_range(0, 1));
      exmem_store_data = $urandom(); memwb_load_data = $urandom();
      step("rand");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule